// File: doc/BRIEF.md
# Serial Configuration Loader with Hold-Qualified Transfer

This block receives a configuration word over three slow serial inputs: a serial clock, a data line and a hold line. All three are brought into the system clock domain through a shared synchronizer, so they stay aligned with one another. Each rising edge of the synchronized serial clock shifts one data bit into a shadow register. Bits enter at the top bit and move toward bit 0, so the first bit sent ends up in bit 0 of the 57-bit word.

The hold level is captured on the same serial edge as the data bit. While it is low, shifting leaves the live configuration untouched. When it is high, the freshly shifted shadow value, including the bit that arrived on that edge, is copied into the active register. Every field changes on one system-clock edge. A host normally raises hold together with the last bit of a word.

The active register drives the decoded control fields used by the clock-generation logic downstream:
- divider select and its decoded modulus
- post-scaler source
- reference bypass
- enable-input polarity
- output suppression
- reference edge select
- static board-test level

Top module: `serial_cfg_loader`

## Requirements
- R1: While rst is high, cfg_word becomes 57'h101 (divider code 1, reference bypass set) and the shadow register clears to zero. All derived outputs follow from that value.
- R2: Each rising edge of the synchronized serial clock shifts the shadow register one place toward bit 0 and places ser_data in bit 56. After 57 edges, the first bit sent sits in bit 0.
- R3: A serial edge whose captured hold level is low leaves cfg_word and every derived output unchanged.
- R4: A serial edge whose captured hold level is high loads the shifted shadow value, including the bit captured on that edge, into cfg_word. All outputs change on the same clock edge.
- R5: A high hold level with no rising serial clock causes no transfer.
- R6: When ser_clk rises and clk then rises three times, cfg_word and the outputs show the transfer after the third edge and not after the second. ser_data and ser_hold are already stable at that point.
- R7: Field positions are as follows:
  - div_code = bits 3:0
  - post_sel = bits 5:4
  - ref_bypass = bit 8
  - en_pol = bit 39
  - pclk_off = bit 46
  - ref_fall = bit 56
- R8: div_modulus maps codes 0 to 8 onto 3, 4, 5, 6, 8, 10, 12, 16 and 20. Codes 9 to 15 give 4.
- R9: force_mode is 1 exactly when post_sel is 2'b11. force_level equals bit 7 when force_mode is 1 and is 0 otherwise.
- R10: A serial clock held high for many system cycles shifts, and can transfer, only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial data clock, asynchronous to clk |
| ser_data | input | 1 | Serial data bit |
| ser_hold | input | 1 | Transfer qualifier, captured with each bit |
| cfg_word | output | 57 | Whole active configuration word |
| div_code | output | 4 | Divider select code |
| div_modulus | output | 5 | Decoded divider modulus |
| post_sel | output | 2 | Post-scaler source select |
| ref_bypass | output | 1 | Route reference clock to divider |
| en_pol | output | 1 | Enable input polarity |
| pclk_off | output | 1 | Suppress pixel clock output |
| ref_fall | output | 1 | Lock on falling reference edge |
| force_mode | output | 1 | Static test mode active |
| force_level | output | 1 | Static output level in test mode |

## Verification
A rising ser_clk is seen by the output registers three system-clock edges after it is applied: two synchronizer stages, then the edge detect that updates the shadow and active registers together. The reference model keeps a short queue of sampled inputs and acts on the entry from two edges earlier. It compares every output at each falling clock edge, half a cycle after the registers settle. The directed latency check samples after the second and third edges to pin that count exactly. Inputs only change at falling edges.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;

    localparam int CFG_W         = 57;
    localparam int DIV_W         = 4;
    localparam int POST_W        = 2;
    localparam int MOD_W         = 5;
    localparam int POS_DIV_LO    = 0;
    localparam int POS_POST_LO   = 4;
    localparam int POS_FORCE_LVL = 7;
    localparam int POS_REF_BYP   = 8;
    localparam int POS_EN_POL    = 39;
    localparam int POS_PCLK_OFF  = 46;
    localparam int POS_REF_FALL  = 56;

    localparam logic [DIV_W-1:0] DIV_CODE_RESET = DIV_W'(1);

    typedef logic [CFG_W-1:0] cfg_word_t;

    typedef enum logic [POST_W-1:0] {
        POST_VCO    = 2'd0,
        POST_DIV2   = 2'd1,
        POST_DIV4   = 2'd2,
        POST_STATIC = 2'd3
    } post_sel_e;

    typedef struct packed {
        logic [DIV_W-1:0] div_code;
        logic [MOD_W-1:0] div_mod;
        post_sel_e        post_sel;
        logic             ref_bypass;
        logic             en_pol;
        logic             pclk_off;
        logic             ref_fall;
        logic             force_mode;
        logic             force_level;
    } cfg_fields_t;

    function automatic cfg_word_t reset_word();
        cfg_word_t w;
        w = '0;
        w[POS_DIV_LO +: DIV_W] = DIV_CODE_RESET;
        w[POS_REF_BYP]         = 1'b1;
        return w;
    endfunction

    function automatic logic [MOD_W-1:0] div_modulus(input logic [DIV_W-1:0] code);
        logic [MOD_W-1:0] m;
        case (code)
            4'd0:    m = 5'd3;
            4'd1:    m = 5'd4;
            4'd2:    m = 5'd5;
            4'd3:    m = 5'd6;
            4'd4:    m = 5'd8;
            4'd5:    m = 5'd10;
            4'd6:    m = 5'd12;
            4'd7:    m = 5'd16;
            4'd8:    m = 5'd20;
            default: m = 5'd4;
        endcase
        return m;
    endfunction

    function automatic cfg_fields_t unpack_cfg(input cfg_word_t w);
        cfg_fields_t f;
        f.div_code    = w[POS_DIV_LO +: DIV_W];
        f.div_mod     = div_modulus(w[POS_DIV_LO +: DIV_W]);
        f.post_sel    = post_sel_e'(w[POS_POST_LO +: POST_W]);
        f.ref_bypass  = w[POS_REF_BYP];
        f.en_pol      = w[POS_EN_POL];
        f.pclk_off    = w[POS_PCLK_OFF];
        f.ref_fall    = w[POS_REF_FALL];
        f.force_mode  = (f.post_sel == POST_STATIC);
        f.force_level = f.force_mode & w[POS_FORCE_LVL];
        return f;
    endfunction

endpackage

// File: rtl/sercfg_sync.sv
module sercfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ser_clk,
    input  logic ser_data,
    input  logic ser_hold,
    output logic bit_stb,
    output logic bit_val,
    output logic hold_val
);
    localparam int LAST = STAGES - 1;
    localparam int LANES = 3;
    localparam int L_CLK = 2;
    localparam int L_DAT = 1;
    localparam int L_HLD = 0;

    // clock, data and hold travel through identical stages so they stay aligned
    logic [LANES-1:0] pipe [STAGES];
    logic             clk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= {ser_clk, ser_data, ser_hold};
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) clk_prev <= 1'b0;
        else     clk_prev <= pipe[LAST][L_CLK];
    end

    assign bit_stb  = pipe[LAST][L_CLK] & ~clk_prev;
    assign bit_val  = pipe[LAST][L_DAT];
    assign hold_val = pipe[LAST][L_HLD];

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        bit_stb |=> !bit_stb); // R10

endmodule

// File: rtl/sercfg_shadow.sv
module sercfg_shadow
    import sercfg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      shift_en,
    input  logic      bit_in,
    output cfg_word_t shadow_q,
    output cfg_word_t shadow_nxt
);
    // new bit enters at the top, older bits move toward bit 0
    assign shadow_nxt = {bit_in, shadow_q[CFG_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst)           shadow_q <= '0;
        else if (shift_en) shadow_q <= shadow_nxt;
    end

    AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (shadow_q[CFG_W-2:0] == $past(shadow_q[CFG_W-1:1]))
                     && (shadow_q[CFG_W-1] == $past(bit_in))); // R2
    AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(shadow_q)); // R2

endmodule

// File: rtl/sercfg_active.sv
module sercfg_active
    import sercfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load_en,
    input  cfg_word_t   load_val,
    output cfg_word_t   active_q,
    output cfg_fields_t fields
);
    always_ff @(posedge clk) begin
        if (rst)          active_q <= reset_word();
        else if (load_en) active_q <= load_val;
    end

    always_comb fields = unpack_cfg(active_q);

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> $stable(active_q)); // R3
    AST_MOD_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (fields.div_mod == 5'd3)  || (fields.div_mod == 5'd4)  ||
        (fields.div_mod == 5'd5)  || (fields.div_mod == 5'd6)  ||
        (fields.div_mod == 5'd8)  || (fields.div_mod == 5'd10) ||
        (fields.div_mod == 5'd12) || (fields.div_mod == 5'd16) ||
        (fields.div_mod == 5'd20)); // R8
    AST_FORCE_STATIC: assert property (@(posedge clk) disable iff (rst)
        fields.force_level |-> fields.force_mode); // R9

endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
    import sercfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_clk,
    input  logic             ser_data,
    input  logic             ser_hold,
    output logic [CFG_W-1:0] cfg_word,
    output logic [DIV_W-1:0] div_code,
    output logic [MOD_W-1:0] div_modulus,
    output logic [POST_W-1:0] post_sel,
    output logic             ref_bypass,
    output logic             en_pol,
    output logic             pclk_off,
    output logic             ref_fall,
    output logic             force_mode,
    output logic             force_level
);
    logic        bit_stb;
    logic        bit_val;
    logic        hold_val;
    logic        xfer;
    cfg_word_t   shadow_q;
    cfg_word_t   shadow_nxt;
    cfg_word_t   active_q;
    cfg_fields_t fields;

    sercfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .ser_clk  (ser_clk),
        .ser_data (ser_data),
        .ser_hold (ser_hold),
        .bit_stb  (bit_stb),
        .bit_val  (bit_val),
        .hold_val (hold_val)
    );

    sercfg_shadow u_shadow (
        .clk        (clk),
        .rst        (rst),
        .shift_en   (bit_stb),
        .bit_in     (bit_val),
        .shadow_q   (shadow_q),
        .shadow_nxt (shadow_nxt)
    );

    // hold only counts when captured alongside a serial edge
    assign xfer = bit_stb & hold_val;

    sercfg_active u_active (
        .clk      (clk),
        .rst      (rst),
        .load_en  (xfer),
        .load_val (shadow_nxt),
        .active_q (active_q),
        .fields   (fields)
    );

    assign cfg_word    = active_q;
    assign div_code    = fields.div_code;
    assign div_modulus = fields.div_mod;
    assign post_sel    = fields.post_sel;
    assign ref_bypass  = fields.ref_bypass;
    assign en_pol      = fields.en_pol;
    assign pclk_off    = fields.pclk_off;
    assign ref_fall    = fields.ref_fall;
    assign force_mode  = fields.force_mode;
    assign force_level = fields.force_level;

    AST_XFER_MATCH: assert property (@(posedge clk) disable iff (rst)
        xfer |=> (cfg_word == shadow_q)); // R4
    AST_NO_XFER_IDLE: assert property (@(posedge clk) disable iff (rst)
        !bit_stb |=> $stable(cfg_word)); // R5

endmodule

// File: tb/serial_cfg_loader_tb.sv
module serial_cfg_loader_tb;

    localparam int W = 57;
    localparam int WATCHDOG = 150000;
    localparam logic [W-1:0] DEF_WORD = 57'h101;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0;
    logic ser_data = 1'b0;
    logic ser_hold = 1'b0;

    logic [W-1:0] cfg_word;
    logic [3:0]   div_code;
    logic [4:0]   div_modulus;
    logic [1:0]   post_sel;
    logic         ref_bypass, en_pol, pclk_off, ref_fall, force_mode, force_level;

    always #5 clk = ~clk;

    serial_cfg_loader u_dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data), .ser_hold(ser_hold),
        .cfg_word(cfg_word), .div_code(div_code), .div_modulus(div_modulus),
        .post_sel(post_sel), .ref_bypass(ref_bypass), .en_pol(en_pol),
        .pclk_off(pclk_off), .ref_fall(ref_fall), .force_mode(force_mode),
        .force_level(force_level)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit started = 0;

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [4:0] exp_mod(input logic [3:0] c);
        case (c)
            4'd0: return 5'd3;   4'd1: return 5'd4;   4'd2: return 5'd5;
            4'd3: return 5'd6;   4'd4: return 5'd8;   4'd5: return 5'd10;
            4'd6: return 5'd12;  4'd7: return 5'd16;  4'd8: return 5'd20;
            default: return 5'd4;
        endcase
    endfunction

    // reference model: input samples queued, acted on two edges later
    logic [W-1:0] m_shadow = '0;
    logic [W-1:0] m_active = DEF_WORD;
    logic [2:0] q_clk = '0, q_dat = '0, q_hld = '0;

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            q_clk = '0; q_dat = '0; q_hld = '0;
            m_shadow = '0;
            m_active = DEF_WORD;
        end else begin
            if (q_clk[1] && !q_clk[2]) begin
                m_shadow = {q_dat[1], m_shadow[W-1:1]};
                if (q_hld[1]) m_active = m_shadow;
            end
            q_clk = {q_clk[1:0], ser_clk};
            q_dat = {q_dat[1:0], ser_data};
            q_hld = {q_hld[1:0], ser_hold};
        end
    end

    always @(negedge clk) begin
        if (started) begin
            logic pf;
            pf = (m_active[5:4] == 2'b11);
            chk(64'(cfg_word),    64'(m_active),        "R4 model cfg_word");
            chk(64'(div_code),    64'(m_active[3:0]),   "R7 model div_code");
            chk(64'(div_modulus), 64'(exp_mod(m_active[3:0])), "R8 model div_modulus");
            chk(64'(post_sel),    64'(m_active[5:4]),   "R7 model post_sel");
            chk(64'(ref_bypass),  64'(m_active[8]),     "R7 model ref_bypass");
            chk(64'(en_pol),      64'(m_active[39]),    "R7 model en_pol");
            chk(64'(pclk_off),    64'(m_active[46]),    "R7 model pclk_off");
            chk(64'(ref_fall),    64'(m_active[56]),    "R7 model ref_fall");
            chk(64'(force_mode),  64'(pf),              "R9 model force_mode");
            chk(64'(force_level), 64'(pf & m_active[7]), "R9 model force_level");
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R6 actual=%0d cycles expected<=%0d", cyc, WATCHDOG);
            finish_run();
        end
    end

    task automatic send_bit(input logic d, input logic h);
        @(negedge clk);
        ser_data = d; ser_hold = h; ser_clk = 1'b0;
        repeat (3) @(negedge clk);
        ser_clk = 1'b1;
        repeat (3) @(negedge clk);
        ser_clk = 1'b0; ser_hold = 1'b0;
    endtask

    task automatic send_word(input logic [W-1:0] w, input logic load);
        for (int i = 0; i < W; i++) send_bit(w[i], load && (i == W-1));
        repeat (4) @(negedge clk);
    endtask

    logic [W-1:0] wa, wb, wc;

    initial begin
        wa = {1'b1, 56'h5A3C96F01E2D45} | (57'd1 << 46) | (57'd1 << 39);
        wb = 57'h0F0_1234_5678_9ABC;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(64'(cfg_word), 64'(DEF_WORD), "R1 reset cfg_word");
        chk(64'(div_modulus), 64'd4, "R1 reset div_modulus");
        chk(64'(ref_bypass), 64'd1, "R1 reset ref_bypass");
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R6 latency on final bit of wa
        for (int i = 0; i < W-1; i++) send_bit(wa[i], 1'b0);
        @(negedge clk);
        ser_data = wa[W-1]; ser_hold = 1'b1; ser_clk = 1'b0;
        repeat (3) @(negedge clk);
        ser_clk = 1'b1;
        @(negedge clk);
        chk(64'(cfg_word), 64'(DEF_WORD), "R6 unchanged after 1 edge");
        @(negedge clk);
        chk(64'(cfg_word), 64'(DEF_WORD), "R6 unchanged after 2 edges");
        @(negedge clk);
        chk(64'(cfg_word), 64'(wa), "R6 loaded after 3 edges (R2 bit order)");
        repeat (2) @(negedge clk);
        ser_clk = 1'b0; ser_hold = 1'b0;
        repeat (4) @(negedge clk);

        // R7 field positions
        chk(64'(en_pol),   64'(wa[39]), "R7 en_pol bit 39");
        chk(64'(pclk_off), 64'(wa[46]), "R7 pclk_off bit 46");
        chk(64'(ref_fall), 64'(wa[56]), "R7 ref_fall bit 56");
        chk(64'(div_code), 64'(wa[3:0]), "R7 div_code bits 3:0");
        chk(64'(ref_bypass), 64'(wa[8]), "R7 ref_bypass bit 8");

        // R3 shifting with hold low
        send_word(wb, 1'b0);
        chk(64'(cfg_word), 64'(wa), "R3 hold low keeps config");

        // R5 hold high without serial edge
        @(negedge clk);
        ser_hold = 1'b1;
        repeat (10) @(negedge clk);
        chk(64'(cfg_word), 64'(wa), "R5 hold without edge");

        // R10 serial clock held high: one shift, one transfer
        ser_data = 1'b1;
        ser_clk = 1'b1;
        repeat (5) @(negedge clk);
        chk(64'(cfg_word), 64'({1'b1, wb[W-1:1]}), "R10 single shift and transfer");
        ser_data = 1'b0;
        repeat (20) @(negedge clk);
        chk(64'(cfg_word), 64'({1'b1, wb[W-1:1]}), "R10 no repeat while high");
        ser_clk = 1'b0; ser_hold = 1'b0;
        repeat (4) @(negedge clk);

        // R8 divider decode over all codes
        for (int c = 0; c < 16; c++) begin
            wc = wb;
            wc[3:0] = 4'(c);
            send_word(wc, 1'b1);
            chk(64'(div_modulus), 64'(exp_mod(4'(c))), "R8 divider modulus");
        end

        // R9 static test mode
        wc = '0; wc[5:4] = 2'b11; wc[7] = 1'b1;
        send_word(wc, 1'b1);
        chk(64'(force_mode), 64'd1, "R9 force_mode set");
        chk(64'(force_level), 64'd1, "R9 force_level high");
        wc[7] = 1'b0;
        send_word(wc, 1'b1);
        chk(64'(force_level), 64'd0, "R9 force_level low");
        wc[5:4] = 2'b10; wc[7] = 1'b1;
        send_word(wc, 1'b1);
        chk(64'(force_mode), 64'd0, "R9 force_mode clear");
        chk(64'(force_level), 64'd0, "R9 level masked");

        // R4 mid-word hold transfers partial shift
        send_bit(1'b1, 1'b0);
        send_bit(1'b0, 1'b1);
        repeat (4) @(negedge clk);
        chk(64'(cfg_word), 64'({1'b0, 1'b1, wc[W-1:2]}), "R4 partial transfer");

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule